// File: doc/BRIEF.md
# Four-Channel PCM Time-Slot Serial Port

This block is the serial front end of a four-channel voice codec. It runs on the PCM bit clock. Each channel has one transmit sync input and one receive sync input. A one-clock pulse on a sync input opens that channel's eight-bit time slot. During a transmit slot, the channel shifts its companded byte onto a shared transmit line, most significant bit first. During a receive slot, it collects a byte from a shared receive line in the same bit order. Outside any transmit slot the line is released. The release is shown by an output-enable pin, and an active-low slot indicator models the open-drain pin that marks line activity.

On the datapath side, each channel takes its next outgoing byte through a valid/ready stream port. Behind that port sits a one-entry holding register. The register is emptied when the channel's slot opens, and `tx_ready` stays low while it holds a byte. Received bytes leave through a valid-only port with a one-clock strobe. A TDM line cannot be paused, so this port has no back-pressure, and the consumer must take each byte in the cycle it is strobed. A companding-law select is registered once and handed on to the datapath.

Top module: `pcm_tdm_port`

## Requirements
- R1: A transmit slot for channel i opens at the rising edge E0 where `tx_fs[i]` is sampled high while that channel is idle. During the cycle after edge E0+k (k = 0..7), bit 7-k of the slot's byte is on `pcm_tx`.
- R2: `pcm_tx_oe` is high exactly in the cycles in which at least one transmit slot is open. When it is low, `pcm_tx` is 0, which stands for high impedance.
- R3: `slot_n` is low exactly when some channel is driving the transmit line, and high otherwise.
- R4: Each channel's transmit stream has a one-entry holding register. `tx_ready[i]` is high when the register is empty, and a byte is taken on an edge where `tx_valid[i]` and `tx_ready[i]` are both high. The register is emptied at slot open. If it is empty at slot open, the idle byte 0xFF is sent.
- R5: `pcm_rx` is sampled on the falling edge. Receive slot i opens at the edge E0 where `rx_fs[i]` is sampled high. The bit sampled on the falling edge inside the cycle after E0+k becomes bit 7-k. The byte appears on `rx_data[i*8 +: 8]` together with a single-cycle `rx_valid[i]` in the cycle after edge E0+8.
- R6: When transmit slots overlap, the lowest-numbered open channel drives `pcm_tx`. `slot_conflict` is high in every cycle in which two or more transmit slots are open.
- R7: A sync pulse sampled at edges E0+1..E0+7 of that channel's own slot is ignored. A pulse at edge E0+8 opens a new slot back to back. This holds for both transmit and receive.
- R8: `law_alaw` equals `law_sel` as sampled at the previous rising edge. The value 0 selects µ-law and 1 selects A-law.
- R9: While `rst_n` is low: `pcm_tx_oe` is 0, `slot_n` is 1, `slot_conflict` is 0, all `rx_valid` bits are 0, all `tx_ready` bits are 1, and `law_alaw` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | PCM bit clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| law_sel | input | 1 | Companding law request (0 µ-law, 1 A-law) |
| law_alaw | output | 1 | Registered law select for the datapath |
| tx_fs | input | 4 | Per-channel transmit slot sync pulses |
| rx_fs | input | 4 | Per-channel receive slot sync pulses |
| pcm_rx | input | 1 | Shared serial receive line |
| pcm_tx | output | 1 | Shared serial transmit line data |
| pcm_tx_oe | output | 1 | Transmit line drive enable (low = high impedance) |
| slot_n | output | 1 | Active-low transmit activity indicator |
| slot_conflict | output | 1 | Two or more transmit slots open at once |
| tx_data | input | 32 | Per-channel outgoing bytes, channel i in bits i*8+7..i*8 |
| tx_valid | input | 4 | Per-channel outgoing byte valid |
| tx_ready | output | 4 | Per-channel holding register empty |
| rx_data | output | 32 | Per-channel received bytes, channel i in bits i*8+7..i*8 |
| rx_valid | output | 4 | Per-channel one-cycle receive strobe |

## Verification
Every fault in this block surfaces on the serial pins within one slot of the event that caused it. If a lane's bit counter is off by one, `pcm_tx_oe` and `slot_n` are held one cycle too long or dropped one cycle early, and `rx_valid` arrives off its cycle. This is visible in the cycle after the eighth bit. If a holding-register flag is stuck, `tx_ready` shows it on the next clock, and the next slot carries the wrong byte or a false 0xFF. A wrong arbitration order shows up only when slots overlap. For that reason the stimulus deliberately opens slots that coincide or overlap, and places repeat syncs both inside a slot and exactly at its end.

// File: rtl/pcm_tdm_pkg.sv
package pcm_tdm_pkg;

  typedef enum logic {
    LAW_MU = 1'b0,
    LAW_A  = 1'b1
  } law_e;

  // What a transmit lane offers to the line arbiter.
  typedef struct packed {
    logic drive;
    logic dbit;
  } tx_lane_t;

endpackage

// File: rtl/pcm_tx_lane.sv
module pcm_tx_lane
  import pcm_tdm_pkg::*;
#(
  parameter int unsigned SAMPLE_W  = 8,
  parameter logic [SAMPLE_W-1:0] IDLE_BYTE = '1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                fs,
  input  logic [SAMPLE_W-1:0] in_data,
  input  logic                in_valid,
  output logic                in_ready,
  output tx_lane_t            lane
);

  localparam int unsigned CW = (SAMPLE_W > 1) ? $clog2(SAMPLE_W) : 1;
  localparam logic [CW-1:0] LAST_IDX = CW'(SAMPLE_W - 1);

  logic [SAMPLE_W-1:0] hold_q;
  logic                hold_full_q;
  logic [SAMPLE_W-1:0] shreg_q;
  logic                act_q;
  logic [CW-1:0]       cnt_q;

  logic last_bit;
  logic start;
  logic accept;

  assign last_bit = act_q && (cnt_q == LAST_IDX);
  assign start    = fs && (!act_q || last_bit);
  assign accept   = in_valid && !hold_full_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg_q <= '0;
      act_q   <= 1'b0;
      cnt_q   <= '0;
    end else if (start) begin
      shreg_q <= hold_full_q ? hold_q : IDLE_BYTE;
      act_q   <= 1'b1;
      cnt_q   <= '0;
    end else if (act_q) begin
      if (last_bit) begin
        act_q <= 1'b0;
      end else begin
        cnt_q   <= cnt_q + 1'b1;
        shreg_q <= {shreg_q[SAMPLE_W-2:0], 1'b0};
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q      <= '0;
      hold_full_q <= 1'b0;
    end else if (start && hold_full_q) begin
      hold_full_q <= 1'b0;
    end else if (accept) begin
      hold_q      <= in_data;
      hold_full_q <= 1'b1;
    end
  end

  assign in_ready   = !hold_full_q;
  assign lane.drive = act_q;
  assign lane.dbit  = shreg_q[SAMPLE_W-1];

endmodule

// File: rtl/pcm_rx_lane.sv
module pcm_rx_lane #(
  parameter int unsigned SAMPLE_W = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                fs,
  input  logic                sbit,
  output logic [SAMPLE_W-1:0] out_data,
  output logic                out_valid
);

  localparam int unsigned CW = (SAMPLE_W > 1) ? $clog2(SAMPLE_W) : 1;
  localparam logic [CW-1:0] LAST_IDX = CW'(SAMPLE_W - 1);

  logic [SAMPLE_W-1:0] shreg_q;
  logic                act_q;
  logic [CW-1:0]       cnt_q;
  logic                last_bit;
  logic                start;
  logic [SAMPLE_W-1:0] shifted;

  assign last_bit = act_q && (cnt_q == LAST_IDX);
  assign start    = fs && (!act_q || last_bit);
  assign shifted  = {shreg_q[SAMPLE_W-2:0], sbit};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg_q   <= '0;
      act_q     <= 1'b0;
      cnt_q     <= '0;
      out_data  <= '0;
      out_valid <= 1'b0;
    end else begin
      out_valid <= 1'b0;
      if (act_q) begin
        shreg_q <= shifted;
        if (last_bit) begin
          out_data  <= shifted;
          out_valid <= 1'b1;
        end
      end
      if (start) begin
        act_q <= 1'b1;
        cnt_q <= '0;
      end else if (act_q) begin
        if (last_bit) act_q <= 1'b0;
        else          cnt_q <= cnt_q + 1'b1;
      end
    end
  end

endmodule

// File: rtl/pcm_tx_arbiter.sv
module pcm_tx_arbiter
  import pcm_tdm_pkg::*;
#(
  parameter int unsigned NCH = 4
) (
  input  tx_lane_t [NCH-1:0] lanes,
  output logic               line,
  output logic               oe,
  output logic               slot_n,
  output logic               conflict
);

  localparam int unsigned NW = $clog2(NCH + 1);

  logic [NW-1:0] n_act;
  logic          found;

  always_comb begin
    line  = 1'b0;
    found = 1'b0;
    n_act = '0;
    for (int i = 0; i < NCH; i++) begin
      if (lanes[i].drive) begin
        n_act = n_act + 1'b1;
        if (!found) begin
          line  = lanes[i].dbit;
          found = 1'b1;
        end
      end
    end
  end

  assign oe       = found;
  assign slot_n   = (n_act == '0);
  assign conflict = (n_act > NW'(1));

endmodule

// File: rtl/pcm_tdm_port.sv
module pcm_tdm_port
  import pcm_tdm_pkg::*;
#(
  parameter int unsigned NCH       = 4,
  parameter int unsigned SAMPLE_W  = 8,
  parameter logic [SAMPLE_W-1:0] IDLE_BYTE = '1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    law_sel,
  output logic                    law_alaw,
  input  logic [NCH-1:0]          tx_fs,
  input  logic [NCH-1:0]          rx_fs,
  input  logic                    pcm_rx,
  output logic                    pcm_tx,
  output logic                    pcm_tx_oe,
  output logic                    slot_n,
  output logic                    slot_conflict,
  input  logic [NCH*SAMPLE_W-1:0] tx_data,
  input  logic [NCH-1:0]          tx_valid,
  output logic [NCH-1:0]          tx_ready,
  output logic [NCH*SAMPLE_W-1:0] rx_data,
  output logic [NCH-1:0]          rx_valid
);

  tx_lane_t [NCH-1:0] lanes;
  logic               rx_fall_q;
  law_e               law_q;

  // Receive line sampled mid-bit on the falling edge.
  always_ff @(negedge clk) begin
    rx_fall_q <= pcm_rx;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) law_q <= LAW_MU;
    else        law_q <= law_e'(law_sel);
  end
  assign law_alaw = (law_q == LAW_A);

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    pcm_tx_lane #(
      .SAMPLE_W  (SAMPLE_W),
      .IDLE_BYTE (IDLE_BYTE)
    ) u_tx (
      .clk      (clk),
      .rst_n    (rst_n),
      .fs       (tx_fs[g]),
      .in_data  (tx_data[g*SAMPLE_W +: SAMPLE_W]),
      .in_valid (tx_valid[g]),
      .in_ready (tx_ready[g]),
      .lane     (lanes[g])
    );

    pcm_rx_lane #(
      .SAMPLE_W (SAMPLE_W)
    ) u_rx (
      .clk       (clk),
      .rst_n     (rst_n),
      .fs        (rx_fs[g]),
      .sbit      (rx_fall_q),
      .out_data  (rx_data[g*SAMPLE_W +: SAMPLE_W]),
      .out_valid (rx_valid[g])
    );
  end

  pcm_tx_arbiter #(
    .NCH (NCH)
  ) u_arb (
    .lanes    (lanes),
    .line     (pcm_tx),
    .oe       (pcm_tx_oe),
    .slot_n   (slot_n),
    .conflict (slot_conflict)
  );

endmodule

// File: rtl/pcm_tdm_port_chk.sv
module pcm_tdm_port_chk #(
  parameter int unsigned NCH      = 4,
  parameter int unsigned SAMPLE_W = 8
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    law_sel,
  input logic                    law_alaw,
  input logic [NCH-1:0]          tx_fs,
  input logic                    pcm_tx,
  input logic                    pcm_tx_oe,
  input logic                    slot_n,
  input logic                    slot_conflict,
  input logic [NCH-1:0]          tx_valid,
  input logic [NCH-1:0]          tx_ready,
  input logic [NCH-1:0]          rx_valid
);

  // R9: quiet outputs while reset is held
  a_r9_reset_quiet: assert property (@(posedge clk)
    !rst_n |-> (slot_n && !pcm_tx_oe && !slot_conflict && rx_valid == '0 && tx_ready == '1));

  // R6: a conflict only exists while the line is driven
  a_r6_conflict_driven: assert property (@(posedge clk) disable iff (!rst_n)
    slot_conflict |-> (!slot_n && pcm_tx_oe));

  // R2: released line carries 0
  a_r2_idle_line_low: assert property (@(posedge clk) disable iff (!rst_n)
    slot_n |-> !pcm_tx);

  // R8: law select delayed by one edge
  a_r8_law_follow: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> (law_alaw == $past(law_sel)));

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    // R1: a sync on an idle line opens a slot at the next edge
    a_r1_sync_opens: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_fs[g] && !pcm_tx_oe) |=> pcm_tx_oe);

    // R5: receive strobe lasts one cycle
    a_r5_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
      rx_valid[g] |=> !rx_valid[g]);

    // R4: an accepted byte fills the holding register
    a_r4_accept_fills: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_valid[g] && tx_ready[g]) |=> !tx_ready[g]);
  end

endmodule

bind pcm_tdm_port pcm_tdm_port_chk #(
  .NCH      (NCH),
  .SAMPLE_W (SAMPLE_W)
) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .law_sel       (law_sel),
  .law_alaw      (law_alaw),
  .tx_fs         (tx_fs),
  .pcm_tx        (pcm_tx),
  .pcm_tx_oe     (pcm_tx_oe),
  .slot_n        (slot_n),
  .slot_conflict (slot_conflict),
  .tx_valid      (tx_valid),
  .tx_ready      (tx_ready),
  .rx_valid      (rx_valid)
);

// File: tb/sim_pcm_tdm_port.sv
module sim_pcm_tdm_port;

  localparam int NCH = 4;
  localparam int W   = 8;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic           rst_n = 1'b0;
  logic           law_sel = 1'b0;
  logic           law_alaw;
  logic [NCH-1:0] tx_fs = '0;
  logic [NCH-1:0] rx_fs = '0;
  logic           pcm_rx = 1'b0;
  logic           pcm_tx, pcm_tx_oe, slot_n, slot_conflict;
  logic [NCH*W-1:0] tx_data = '0;
  logic [NCH-1:0] tx_valid = '0;
  logic [NCH-1:0] tx_ready;
  logic [NCH*W-1:0] rx_data;
  logic [NCH-1:0] rx_valid;

  pcm_tdm_port u0 (
    .clk(clk), .rst_n(rst_n), .law_sel(law_sel), .law_alaw(law_alaw),
    .tx_fs(tx_fs), .rx_fs(rx_fs), .pcm_rx(pcm_rx), .pcm_tx(pcm_tx),
    .pcm_tx_oe(pcm_tx_oe), .slot_n(slot_n), .slot_conflict(slot_conflict),
    .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready),
    .rx_data(rx_data), .rx_valid(rx_valid)
  );

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
    end
  endtask

  // Behavioural reference model
  int         tpos [NCH];   // bit index being driven, -1 idle
  logic [7:0] tbyte[NCH];
  logic [7:0] holdq[NCH][$];
  int         rpos [NCH];   // bits collected, -1 idle
  logic [7:0] racc [NCH];
  logic [7:0] rout [NCH];
  bit         rv   [NCH];
  bit         law_m;
  bit         ignored;

  initial begin
    for (int i = 0; i < NCH; i++) begin
      tpos[i] = -1; rpos[i] = -1; tbyte[i] = '0; racc[i] = '0; rout[i] = '0; rv[i] = 0;
    end
    law_m = 0;
  end

  always @(posedge clk) begin
    ignored = 0;
    if (!rst_n) begin
      for (int i = 0; i < NCH; i++) begin
        tpos[i] = -1; rpos[i] = -1; rout[i] = '0; rv[i] = 0;
        holdq[i].delete();
      end
      law_m = 0;
    end else begin
      for (int i = 0; i < NCH; i++) begin
        bit acc, rs;
        acc = tx_valid[i] && (holdq[i].size() == 0);
        if (tx_fs[i] && (tpos[i] < 0 || tpos[i] == W-1)) begin
          tpos[i]  = 0;
          tbyte[i] = (holdq[i].size() != 0) ? holdq[i].pop_front() : 8'hFF;
        end else begin
          if (tx_fs[i]) ignored = 1;
          if (tpos[i] >= 0) tpos[i] = (tpos[i] == W-1) ? -1 : tpos[i] + 1;
        end
        if (acc) holdq[i].push_back(tx_data[i*W +: W]);

        rs = rx_fs[i] && (rpos[i] < 0 || rpos[i] == W-1);
        if (rx_fs[i] && !rs) ignored = 1;
        rv[i] = 0;
        if (rpos[i] >= 0) begin
          racc[i] = {racc[i][6:0], pcm_rx};
          if (rpos[i] == W-1) begin
            rout[i] = racc[i]; rv[i] = 1; rpos[i] = -1;
          end else rpos[i] = rpos[i] + 1;
        end
        if (rs) rpos[i] = 0;
      end
      law_m = law_sel;
    end
    #8;
    if (rst_n) begin
      int  n;
      bit  eoe, ebit;
      n = 0; eoe = 0; ebit = 0;
      for (int i = 0; i < NCH; i++) begin
        if (tpos[i] >= 0) begin
          n++;
          if (!eoe) begin eoe = 1; ebit = tbyte[i][W-1-tpos[i]]; end
        end
      end
      chk(pcm_tx_oe == eoe, "R2", "pcm_tx_oe", pcm_tx_oe, eoe);
      chk(pcm_tx == ebit, (n > 1) ? "R6" : "R1", "pcm_tx", pcm_tx, ebit);
      chk(slot_n == !eoe, "R3", "slot_n", slot_n, !eoe);
      chk(slot_conflict == (n > 1), "R6", "slot_conflict", slot_conflict, n > 1);
      if (ignored) chk(pcm_tx_oe == eoe && pcm_tx == ebit, "R7", "line after ignored sync",
                       {pcm_tx_oe, pcm_tx}, {eoe, ebit});
      for (int i = 0; i < NCH; i++) begin
        chk(tx_ready[i] == (holdq[i].size() == 0), "R4", $sformatf("tx_ready[%0d]", i),
            tx_ready[i], holdq[i].size() == 0);
        chk(rx_valid[i] == rv[i], "R5", $sformatf("rx_valid[%0d]", i), rx_valid[i], rv[i]);
        if (rv[i])
          chk(rx_data[i*W +: W] == rout[i], "R5", $sformatf("rx_data[%0d]", i),
              rx_data[i*W +: W], rout[i]);
      end
      chk(law_alaw == law_m, "R8", "law_alaw", law_alaw, law_m);
    end
  end

  task automatic reset_checks();
    chk(pcm_tx_oe == 0, "R9", "pcm_tx_oe in reset", pcm_tx_oe, 0);
    chk(slot_n == 1, "R9", "slot_n in reset", slot_n, 1);
    chk(slot_conflict == 0, "R9", "slot_conflict in reset", slot_conflict, 0);
    chk(rx_valid == '0, "R9", "rx_valid in reset", rx_valid, 0);
    chk(tx_ready == '1, "R9", "tx_ready in reset", tx_ready, 4'hF);
    chk(law_alaw == 0, "R9", "law_alaw in reset", law_alaw, 0);
  endtask

  // mode 0: disjoint slots; 1: overlapping slots (R6);
  // 2: mid-slot and back-to-back syncs, channel 0 starved (R7, R4 idle byte); 3: random syncs
  task automatic run(input int frames, input int mode);
    for (int f = 0; f < frames; f++) begin
      for (int s = 0; s < 32; s++) begin
        @(posedge clk); #2;
        for (int i = 0; i < NCH; i++) begin
          case (mode)
            0: begin tx_fs[i] = (s == i*8); rx_fs[i] = (s == (i*8 + 4) % 32); end
            1: begin
              tx_fs[i] = (i == 1) ? (s == 3) : (i == 3) ? (s == 20) : (s == 0);
              rx_fs[i] = (s == (i*8 + 2) % 32) || (i == 2 && s == 5);
            end
            2: begin
              tx_fs[i] = (i == 0) ? (s == 0 || s == 3 || s == 8) : (s == i*8 + 8 && i < 3);
              rx_fs[i] = (i == 1) ? (s == 0 || s == 5 || s == 8) : (s == (i*8 + 16) % 32);
            end
            default: begin tx_fs[i] = ($urandom % 6 == 0); rx_fs[i] = ($urandom % 6 == 0); end
          endcase
          tx_valid[i] = (mode == 2 && i == 0) ? 1'b0 : 1'($urandom % 2);
          tx_data[i*W +: W] = 8'($urandom);
        end
        pcm_rx = 1'($urandom % 2);
        if (s == 0 || mode == 3) law_sel = 1'($urandom % 2);
      end
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #8 reset_checks();
    @(posedge clk); #2 rst_n = 1'b1;
    run(6, 0);
    run(4, 1);
    run(4, 2);
    run(8, 3);
    @(posedge clk); #2 rst_n = 1'b0;
    @(posedge clk); #8 reset_checks();
    @(posedge clk); #2 rst_n = 1'b1;
    run(4, 0);
    @(posedge clk); #2 tx_fs = '0; rx_fs = '0; tx_valid = '0;
    repeat (12) @(posedge clk);
    #9;
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #(200000 * 10);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog (all requirements) actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

endmodule